// File: doc/BRIEF.md
# Registered Dual-Mode ALU

A clocked arithmetic and logic unit whose operand width is a parameter. A single mode input chooses between two command tables: arithmetic (mode = 1) and bitwise/shift/rotate (mode = 0). A 4-bit command selects the operation inside the chosen table. Every output is a register, and all outputs change only on a rising clock edge while the clock enable is high.

A two-bit operand qualifier tells the unit which operands are currently valid. A command that uses one operand fails at once if that operand is absent. A command that uses both operands waits, holding its outputs, until both are marked valid. It gives up with an error after a bounded number of enabled cycles. Unsupported command codes and illegal rotate amounts also raise the error output. The result port is twice the operand width so that the two multiplying commands can return a full product.

Top module: `dual_mode_alu`

## Requirements
- R1: A low `rst_n` sampled at a rising edge clears `result`, `cout`, `ovf`, `eq`, `gt`, `lt`, `err` to 0 and empties the wait window.
- R2: While `ce` is low, every output holds its value, and the wait count does not advance.
- R3: With `mode`=1, the commands behave as follows. 0 gives A+B and 2 gives A+B+cin; `cout` is the carry and `ovf` is signed overflow. 1 gives A−B and 3 gives A−B−cin; `cout` is the borrow and `ovf` is signed overflow. 4 and 5 give A+1 and A−1. 6 and 7 give B+1 and B−1. 8 is compare. 9 and 10 are the multiply commands. Single-width results are zero-extended.
- R4: With `mode`=0, the commands are: 0 AND, 1 NAND, 2 OR, 3 NOR, 4 XOR, 5 XNOR, 6 ~A, 7 ~B, 8 A>>1, 9 A<<1, 10 B>>1, 11 B<<1, 12 rotate A left by B mod OPW, 13 rotate A right by B mod OPW. Results are zero-extended.
- R5: In `opnd_vld`, bit 0 marks A valid and bit 1 marks B valid. A command that uses only A (arith 4, 5; logic 6, 8, 9) or only B (arith 6, 7; logic 7, 10, 11) sets `err` at the next edge if its operand bit is 0.
- R6: A two-operand command with `opnd_vld`≠11 holds all outputs. At the 16th consecutive such enabled cycle, it sets `err` instead. If 11 arrives earlier, it computes normally and clears the count.
- R7: A rotate (logic 12, 13) with any of B[7:4] set gives `err`. B[3] alone is legal.
- R8: Subtraction with equal operands gives result 0 and `ovf`=0, including the 0x80−0x80 case.
- R9: Increment of all-ones gives result 0 with `cout`=1. Decrement of 0 gives all-ones with `ovf`=1.
- R10: Compare sets exactly one of `eq`, `gt`, `lt` (unsigned A vs B) and leaves `result` at 0. All other commands leave all three at 0.
- R11: Command 9 returns (A+1)·(B+1) and command 10 returns (2A)·B, both 2·OPW bits wide. Product bits above that width set `cout`.
- R12: Undefined codes (arith 11–15, logic 14–15) set `err` at once. Logical commands always leave `cout` and `ovf` at 0.
- R13: Whenever `err` is 1, `result` and all other flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable, active high |
| mode | input | 1 | 1 = arithmetic table, 0 = logical table |
| cmd | input | CMDW | Command code within the selected table |
| opnd_vld | input | 2 | Bit 0: A valid, bit 1: B valid |
| op_a | input | OPW | Operand A |
| op_b | input | OPW | Operand B |
| cin | input | 1 | Carry/borrow input for commands 2 and 3 |
| result | output | 2*OPW | Registered result |
| cout | output | 1 | Carry, borrow or product overflow |
| ovf | output | 1 | Signed overflow or decrement wrap |
| eq | output | 1 | A equals B (compare only) |
| gt | output | 1 | A greater than B (compare only) |
| lt | output | 1 | A less than B (compare only) |
| err | output | 1 | Missing operand, bad command or bad rotate amount |

## Verification
The bench targets the wait window at its edges. With 15 missing cycles the outputs must still hold. With 16 they must flip to error. A counter off by one would error a cycle early or late, and a design that does not hold would show a half-formed result. Subtraction at equal operands and at the 0x80 sign boundary catches a false overflow. Wrap cases of increment and decrement expose a missing carry or borrow. A rotate amount of 0x0B versus 0x10 separates a correct upper-bit check from one that also rejects bit 3. A logical command issued right after an arithmetic carry reveals any `cout` left standing.

// File: rtl/alu_pkg.sv
// Package: command encodings and the operand-need classifier shared by the
// ALU datapath, operand gate and top. Assumes a 4-bit command core.
package alu_pkg;

    typedef enum logic [3:0] {
        A_ADD  = 4'd0,  A_SUB  = 4'd1,  A_ADDC = 4'd2,  A_SUBC = 4'd3,
        A_INCA = 4'd4,  A_DECA = 4'd5,  A_INCB = 4'd6,  A_DECB = 4'd7,
        A_CMP  = 4'd8,  A_IMUL = 4'd9,  A_SMUL = 4'd10
    } arith_op_e;

    typedef enum logic [3:0] {
        L_AND  = 4'd0,  L_NAND = 4'd1,  L_OR   = 4'd2,  L_NOR  = 4'd3,
        L_XOR  = 4'd4,  L_XNOR = 4'd5,  L_NOTA = 4'd6,  L_NOTB = 4'd7,
        L_SHRA = 4'd8,  L_SHLA = 4'd9,  L_SHRB = 4'd10, L_SHLB = 4'd11,
        L_ROL  = 4'd12, L_ROR  = 4'd13
    } logic_op_e;

    typedef enum logic [2:0] {
        NEED_NONE, NEED_A, NEED_B, NEED_AB, NEED_BAD
    } need_e;

    // Classify which operands a command consumes, or flag it unsupported.
    function automatic need_e op_need(input logic arith, input logic [3:0] code);
        need_e n;
        n = NEED_BAD;
        if (arith) begin
            case (code)
                A_ADD, A_SUB, A_ADDC, A_SUBC, A_CMP, A_IMUL, A_SMUL: n = NEED_AB;
                A_INCA, A_DECA:                                      n = NEED_A;
                A_INCB, A_DECB:                                      n = NEED_B;
                default:                                             n = NEED_BAD;
            endcase
        end else begin
            case (code)
                L_AND, L_NAND, L_OR, L_NOR, L_XOR, L_XNOR, L_ROL, L_ROR: n = NEED_AB;
                L_NOTA, L_SHRA, L_SHLA:                                 n = NEED_A;
                L_NOTB, L_SHRB, L_SHLB:                                 n = NEED_B;
                default:                                                n = NEED_BAD;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/alu_arith.sv
// Module: combinational arithmetic datapath for the arithmetic command table.
// Assumes the caller has already qualified operands; unsupported codes
// produce all-zero outputs and are flagged elsewhere.
module alu_arith
    import alu_pkg::*;
#(
    parameter int OPW = 8
) (
    input  arith_op_e        op,
    input  logic [OPW-1:0]   a,
    input  logic [OPW-1:0]   b,
    input  logic             cin,
    output logic [2*OPW-1:0] res,
    output logic             cout,
    output logic             ovf,
    output logic             eq,
    output logic             gt,
    output logic             lt
);
    localparam int MSB = OPW - 1;
    localparam int PW  = 2 * OPW + 2;
    localparam logic [OPW:0] ONE = {{OPW{1'b0}}, 1'b1};

    logic [OPW:0]  s;
    logic [PW-1:0] mx, my, prod;

    // Evaluate the selected arithmetic command and its flags.
    always_comb begin
        s    = '0;
        mx   = '0;
        my   = '0;
        prod = '0;
        res  = '0;
        cout = 1'b0;
        ovf  = 1'b0;
        eq   = 1'b0;
        gt   = 1'b0;
        lt   = 1'b0;
        case (op)
            A_ADD, A_ADDC: begin
                s    = {1'b0, a} + {1'b0, b} + {{OPW{1'b0}}, (op == A_ADDC) & cin};
                res  = {{OPW{1'b0}}, s[OPW-1:0]};
                cout = s[OPW];
                ovf  = (a[MSB] == b[MSB]) && (s[MSB] != a[MSB]);
            end
            A_SUB, A_SUBC: begin
                s    = {1'b0, a} - {1'b0, b} - {{OPW{1'b0}}, (op == A_SUBC) & cin};
                res  = {{OPW{1'b0}}, s[OPW-1:0]};
                cout = s[OPW];
                ovf  = (a[MSB] != b[MSB]) && (s[MSB] != a[MSB]);
            end
            A_INCA, A_INCB: begin
                s    = {1'b0, (op == A_INCA) ? a : b} + ONE;
                res  = {{OPW{1'b0}}, s[OPW-1:0]};
                cout = s[OPW];
            end
            A_DECA, A_DECB: begin
                s    = {1'b0, (op == A_DECA) ? a : b} - ONE;
                res  = {{OPW{1'b0}}, s[OPW-1:0]};
                ovf  = s[OPW];
            end
            A_CMP: begin
                eq = (a == b);
                gt = (a > b);
                lt = (a < b);
            end
            A_IMUL: begin
                mx   = {{(OPW+1){1'b0}}, ({1'b0, a} + ONE)};
                my   = {{(OPW+1){1'b0}}, ({1'b0, b} + ONE)};
                prod = mx * my;
                res  = prod[2*OPW-1:0];
                cout = |prod[PW-1:2*OPW];
            end
            A_SMUL: begin
                mx   = {{(OPW+1){1'b0}}, a, 1'b0};
                my   = {{(OPW+2){1'b0}}, b};
                prod = mx * my;
                res  = prod[2*OPW-1:0];
                cout = |prod[PW-1:2*OPW];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu_logic.sv
// Module: combinational bitwise, shift and rotate datapath for the logical
// command table. Assumes OPW is a power of two so the rotate amount is
// B modulo OPW; flags an illegal rotate when B has bits at or above
// position log2(OPW)+1.
module alu_logic
    import alu_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic_op_e      op,
    input  logic [OPW-1:0] a,
    input  logic [OPW-1:0] b,
    output logic [OPW-1:0] res,
    output logic           rot_err
);
    localparam int SH_W   = $clog2(OPW);
    localparam int RAMT_W = SH_W + 1;

    logic [2*OPW-1:0] dbl, rot;
    logic [SH_W-1:0]  amt;

    // Flag rotate amounts with any bit at or above RAMT_W.
    always_comb rot_err = ((op == L_ROL) || (op == L_ROR)) && (|(b >> RAMT_W));

    // Evaluate the selected logical command.
    always_comb begin
        dbl = {a, a};
        amt = b[SH_W-1:0];
        rot = '0;
        res = '0;
        case (op)
            L_AND:  res = a & b;
            L_NAND: res = ~(a & b);
            L_OR:   res = a | b;
            L_NOR:  res = ~(a | b);
            L_XOR:  res = a ^ b;
            L_XNOR: res = ~(a ^ b);
            L_NOTA: res = ~a;
            L_NOTB: res = ~b;
            L_SHRA: res = a >> 1;
            L_SHLA: res = a << 1;
            L_SHRB: res = b >> 1;
            L_SHLB: res = b << 1;
            L_ROL: begin
                rot = dbl << amt;
                res = rot[2*OPW-1:OPW];
            end
            L_ROR: begin
                rot = dbl >> amt;
                res = rot[OPW-1:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu_opnd_gate.sv
// Module: operand qualifier. Decides per enabled cycle whether the command
// may execute, must fail, or must wait for both operands. Counts consecutive
// enabled waiting cycles and fails the WAIT-th one.
module alu_opnd_gate
    import alu_pkg::*;
#(
    parameter int WAIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce,
    input  need_e      need,
    input  logic [1:0] vld,
    output logic       fail,
    output logic       hold
);
    localparam int CW = (WAIT > 1) ? $clog2(WAIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAIT - 1);

    logic [CW-1:0] cnt;
    logic          miss_one, miss_two, expired;

    // Classify the current cycle from the operand-need and valid bits.
    always_comb begin
        miss_one = ((need == NEED_A) && !vld[0]) || ((need == NEED_B) && !vld[1]);
        miss_two = (need == NEED_AB) && (vld != 2'b11);
        expired  = miss_two && (cnt == LAST);
        fail     = (need == NEED_BAD) || miss_one || expired;
        hold     = miss_two && !expired;
    end

    // Count consecutive enabled waiting cycles; clear on anything else.
    always_ff @(posedge clk) begin
        if (!rst_n)  cnt <= '0;
        else if (ce) cnt <= hold ? cnt + 1'b1 : '0;
    end

    // R6: a fresh operand pair always restarts the window.
    assert_window_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && need == NEED_AB && vld == 2'b11) |=> (cnt == '0));
endmodule

// File: rtl/dual_mode_alu.sv
// Module: top of the registered dual-mode ALU. Selects the arithmetic or
// logical datapath by mode, qualifies operands through the gate and
// registers all outputs. Assumes CMDW >= 4 and OPW a power of two >= 8.
module dual_mode_alu
    import alu_pkg::*;
#(
    parameter int OPW  = 8,
    parameter int CMDW = 4,
    parameter int WAIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              mode,
    input  logic [CMDW-1:0]   cmd,
    input  logic [1:0]        opnd_vld,
    input  logic [OPW-1:0]    op_a,
    input  logic [OPW-1:0]    op_b,
    input  logic              cin,
    output logic [2*OPW-1:0]  result,
    output logic              cout,
    output logic              ovf,
    output logic              eq,
    output logic              gt,
    output logic              lt,
    output logic              err
);
    localparam int RAMT_W = $clog2(OPW) + 1;

    logic [3:0]       code;
    logic             hi_bad;
    need_e            need;
    logic             fail, hold;
    logic [2*OPW-1:0] ar_res;
    logic             ar_cout, ar_ovf, ar_eq, ar_gt, ar_lt;
    logic [OPW-1:0]   lg_res;
    logic             lg_rot_err;

    assign code = cmd[3:0];

    // Command bits above the 4-bit core make the code unsupported.
    generate
        if (CMDW > 4) begin : g_wide_cmd
            assign hi_bad = |cmd[CMDW-1:4];
        end else begin : g_narrow_cmd
            assign hi_bad = 1'b0;
        end
    endgenerate

    // Classify which operands the current command needs.
    always_comb need = hi_bad ? NEED_BAD : op_need(mode, code);

    alu_opnd_gate #(.WAIT(WAIT)) u_gate (
        .clk(clk), .rst_n(rst_n), .ce(ce), .need(need), .vld(opnd_vld),
        .fail(fail), .hold(hold)
    );

    alu_arith #(.OPW(OPW)) u_arith (
        .op(arith_op_e'(code)), .a(op_a), .b(op_b), .cin(cin),
        .res(ar_res), .cout(ar_cout), .ovf(ar_ovf),
        .eq(ar_eq), .gt(ar_gt), .lt(ar_lt)
    );

    alu_logic #(.OPW(OPW)) u_logic (
        .op(logic_op_e'(code)), .a(op_a), .b(op_b),
        .res(lg_res), .rot_err(lg_rot_err)
    );

    // Register the selected outputs, an error word, or hold while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            {cout, ovf, eq, gt, lt, err} <= '0;
        end else if (ce && !hold) begin
            if (fail || (!mode && lg_rot_err)) begin
                result <= '0;
                {cout, ovf, eq, gt, lt} <= '0;
                err <= 1'b1;
            end else if (mode) begin
                result <= ar_res;
                {cout, ovf, eq, gt, lt} <= {ar_cout, ar_ovf, ar_eq, ar_gt, ar_lt};
                err <= 1'b0;
            end else begin
                result <= {{OPW{1'b0}}, lg_res};
                {cout, ovf, eq, gt, lt} <= '0;
                err <= 1'b0;
            end
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !cout && !ovf && !eq && !gt && !lt && !err));

    assert_ce_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(result) && $stable(err) && $stable(cout) && $stable(ovf)));

    assert_single_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && ((need == NEED_A && !opnd_vld[0]) || (need == NEED_B && !opnd_vld[1])))
        |=> err);

    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && hold) |=> ($stable(result) && $stable(err) && $stable(cout)));

    assert_rot_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !mode && !hi_bad && (code == L_ROL || code == L_ROR)
         && opnd_vld == 2'b11 && (|(op_b >> RAMT_W))) |=> err);

    assert_sub_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && mode && !hi_bad && code == A_SUB && opnd_vld == 2'b11 && op_a == op_b)
        |=> (!ovf && result == '0 && !err));

    assert_inc_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && mode && !hi_bad && code == A_INCA && opnd_vld[0] && (&op_a))
        |=> (cout && result == '0));

    assert_cmp_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && mode && !hi_bad && code == A_CMP && opnd_vld == 2'b11)
        |=> ($countones({eq, gt, lt}) == 1));

    assert_logic_noflags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !mode && !hold) |=> (!cout && !ovf));

    assert_err_clean_R13: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (result == '0 && !cout && !ovf && !eq && !gt && !lt));
endmodule

// File: tb/dual_mode_alu_tb.sv
module dual_mode_alu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    typedef struct packed {
        logic [2*W-1:0] res;
        logic co, ov, eq, gt, lt, er;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ce = 1'b0, mode = 1'b0, cin = 1'b0;
    logic [3:0]     cmd = '0;
    logic [1:0]     opnd_vld = '0;
    logic [W-1:0]   op_a = '0, op_b = '0;
    logic [2*W-1:0] result;
    logic           cout, ovf, eq, gt, lt, err;

    int   n_run = 0, n_fail = 0, wcnt = 0;
    bit   done = 0;
    exp_t ex = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_mode_alu #(.OPW(W), .CMDW(4), .WAIT(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .mode(mode), .cmd(cmd),
        .opnd_vld(opnd_vld), .op_a(op_a), .op_b(op_b), .cin(cin),
        .result(result), .cout(cout), .ovf(ovf), .eq(eq), .gt(gt), .lt(lt), .err(err)
    );

    // 1 = A only, 2 = B only, 3 = both, 4 = unsupported
    function automatic int need_of(input logic md, input logic [3:0] c);
        if (md) begin
            if (c <= 3 || (c >= 8 && c <= 10)) return 3;
            if (c == 4 || c == 5) return 1;
            if (c == 6 || c == 7) return 2;
            return 4;
        end
        if (c <= 5 || c == 12 || c == 13) return 3;
        if (c == 6 || c == 8 || c == 9) return 1;
        if (c == 7 || c == 10 || c == 11) return 2;
        return 4;
    endfunction

    function automatic exp_t err_word();
        exp_t e = '0;
        e.er = 1'b1;
        return e;
    endfunction

    function automatic exp_t ref_calc(input logic md, input logic [3:0] c,
                                      input logic [W-1:0] a, input logic [W-1:0] b,
                                      input logic ci);
        exp_t e = '0;
        logic [W:0] s;
        logic [2*W+1:0] p;
        logic [W-1:0] r;
        if (md) begin
            case (c)
                4'd0, 4'd2: begin
                    s = a + b + ((c == 2) ? ci : 1'b0);
                    e.res = s[W-1:0]; e.co = s[W];
                    e.ov = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
                end
                4'd1, 4'd3: begin
                    s = a - b - ((c == 3) ? ci : 1'b0);
                    e.res = s[W-1:0];
                    e.co = ({1'b0, a} < ({1'b0, b} + ((c == 3) ? ci : 1'b0)));
                    e.ov = (a[W-1] != b[W-1]) && (s[W-1] != a[W-1]);
                end
                4'd4: begin e.res = W'(a + 1); e.co = (a == 8'hFF); end
                4'd5: begin e.res = W'(a - 1); e.ov = (a == 8'h00); end
                4'd6: begin e.res = W'(b + 1); e.co = (b == 8'hFF); end
                4'd7: begin e.res = W'(b - 1); e.ov = (b == 8'h00); end
                4'd8: begin e.eq = (a == b); e.gt = (a > b); e.lt = (a < b); end
                4'd9: begin
                    p = (18'(a) + 18'd1) * (18'(b) + 18'd1);
                    e.res = p[15:0]; e.co = |p[17:16];
                end
                4'd10: begin
                    p = (18'(a) * 18'd2) * 18'(b);
                    e.res = p[15:0]; e.co = |p[17:16];
                end
                default: e = err_word();
            endcase
        end else begin
            case (c)
                4'd0: r = a & b;      4'd1: r = ~(a & b);
                4'd2: r = a | b;      4'd3: r = ~(a | b);
                4'd4: r = a ^ b;      4'd5: r = ~(a ^ b);
                4'd6: r = ~a;         4'd7: r = ~b;
                4'd8: r = a >> 1;     4'd9: r = a << 1;
                4'd10: r = b >> 1;    4'd11: r = b << 1;
                4'd12: begin r = a; for (int i = 0; i < int'(b[2:0]); i++) r = {r[W-2:0], r[W-1]}; end
                4'd13: begin r = a; for (int i = 0; i < int'(b[2:0]); i++) r = {r[0], r[W-1:1]}; end
                default: r = '0;
            endcase
            if (c >= 14 || ((c == 12 || c == 13) && b[7:4] != 0)) e = err_word();
            else e.res = {8'h00, r};
        end
        return e;
    endfunction

    task automatic check_out(input string tag);
        exp_t got;
        got = '{res: result, co: cout, ov: ovf, eq: eq, gt: gt, lt: lt, er: err};
        n_run++;
        if (got !== ex) begin
            n_fail++;
            $display("FAIL %s: actual res=%h co=%b ov=%b eq=%b gt=%b lt=%b err=%b expected res=%h co=%b ov=%b eq=%b gt=%b lt=%b err=%b",
                     tag, got.res, got.co, got.ov, got.eq, got.gt, got.lt, got.er,
                     ex.res, ex.co, ex.ov, ex.eq, ex.gt, ex.lt, ex.er);
        end
    endtask

    // Drive one cycle at a falling edge, update the model, check at next falling edge.
    task automatic cyc(input logic c_e, input logic md, input logic [3:0] c,
                       input logic [1:0] v, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ci, input string tag);
        int nd;
        ce = c_e; mode = md; cmd = c; opnd_vld = v; op_a = a; op_b = b; cin = ci;
        if (c_e) begin
            nd = need_of(md, c);
            if (nd == 4 || (nd == 1 && !v[0]) || (nd == 2 && !v[1])) begin
                ex = err_word(); wcnt = 0;
            end else if (nd == 3 && v != 2'b11) begin
                if (wcnt == 15) begin ex = err_word(); wcnt = 0; end
                else wcnt++;
            end else begin
                ex = ref_calc(md, c, a, b, ci); wcnt = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        ce = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ex = '0; wcnt = 0;
        check_out(tag);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset("R1 reset");
        // R3 / R8 / R9 / R10 / R11 arithmetic directed cases
        cyc(1, 1, 4'd0,  2'b11, 8'd200, 8'd100, 0, "R3 add carry");
        cyc(1, 1, 4'd2,  2'b11, 8'h7F, 8'h00, 1, "R3 add cin overflow");
        cyc(1, 1, 4'd1,  2'b11, 8'h80, 8'h80, 0, "R8 sub equal");
        cyc(1, 1, 4'd1,  2'b11, 8'h80, 8'h01, 0, "R8 sub overflow");
        cyc(1, 1, 4'd3,  2'b11, 8'h05, 8'h05, 1, "R8 subc borrow");
        cyc(1, 1, 4'd3,  2'b11, 8'h33, 8'h33, 0, "R8 subc equal");
        cyc(1, 1, 4'd4,  2'b01, 8'hFF, 8'h00, 0, "R9 inc A wrap");
        cyc(1, 1, 4'd7,  2'b10, 8'h00, 8'h00, 0, "R9 dec B wrap");
        cyc(1, 1, 4'd5,  2'b01, 8'h00, 8'h00, 0, "R9 dec A wrap");
        cyc(1, 1, 4'd6,  2'b10, 8'h00, 8'hFF, 0, "R9 inc B wrap");
        cyc(1, 1, 4'd8,  2'b11, 8'h10, 8'h10, 0, "R10 cmp equal");
        cyc(1, 1, 4'd8,  2'b11, 8'h11, 8'h10, 0, "R10 cmp greater");
        cyc(1, 1, 4'd8,  2'b11, 8'h0F, 8'h10, 0, "R10 cmp less");
        cyc(1, 1, 4'd9,  2'b11, 8'h03, 8'h04, 0, "R11 inc-mul small");
        cyc(1, 1, 4'd9,  2'b11, 8'hFF, 8'hFF, 0, "R11 inc-mul max");
        cyc(1, 1, 4'd10, 2'b11, 8'h80, 8'hFF, 0, "R11 shift-mul");
        // R4 / R7 logical directed cases
        cyc(1, 1, 4'd4,  2'b01, 8'hFF, 8'h00, 0, "R9 carry set");
        cyc(1, 0, 4'd2,  2'b11, 8'hA0, 8'h05, 0, "R12 logic clears carry");
        cyc(1, 0, 4'd12, 2'b11, 8'h81, 8'h01, 0, "R4 rotate left");
        cyc(1, 0, 4'd13, 2'b11, 8'h81, 8'h0B, 0, "R7 rotate bit3 legal");
        cyc(1, 0, 4'd13, 2'b11, 8'h81, 8'h10, 0, "R7 rotate illegal");
        cyc(1, 0, 4'd1,  2'b11, 8'hF0, 8'hFF, 0, "R13 error clears");
        cyc(1, 0, 4'd9,  2'b01, 8'hC3, 8'h00, 0, "R4 shl A");
        // R12 unsupported codes
        cyc(1, 1, 4'd12, 2'b11, 8'h01, 8'h02, 0, "R12 bad arith code");
        cyc(1, 0, 4'd15, 2'b11, 8'h01, 8'h02, 0, "R12 bad logic code");
        // R5 single operand missing
        cyc(1, 1, 4'd4,  2'b10, 8'h01, 8'h02, 0, "R5 inc A missing");
        cyc(1, 0, 4'd7,  2'b01, 8'h01, 8'h02, 0, "R5 not B missing");
        // R6 wait window
        cyc(1, 1, 4'd0,  2'b11, 8'd10, 8'd20, 0, "R6 setup");
        for (int i = 0; i < 5; i++) cyc(1, 1, 4'd0, 2'b01, 8'd1, 8'd2, 0, "R6 waiting hold");
        cyc(1, 1, 4'd0,  2'b11, 8'd1, 8'd2, 0, "R6 arrive in window");
        for (int i = 0; i < 15; i++) cyc(1, 1, 4'd0, 2'b00, 8'd7, 8'd9, 0, "R6 hold to 15");
        cyc(1, 1, 4'd0,  2'b00, 8'd7, 8'd9, 0, "R6 expire at 16");
        // R2 clock enable low, including mid-window
        cyc(1, 1, 4'd0,  2'b11, 8'd5, 8'd6, 0, "R2 setup");
        for (int i = 0; i < 14; i++) cyc(1, 1, 4'd1, 2'b10, 8'd9, 8'd1, 0, "R6 partial wait");
        for (int i = 0; i < 4; i++) cyc(0, 1, 4'd0, 2'b00, 8'hAA, 8'h55, 1, "R2 ce low hold");
        cyc(1, 1, 4'd1,  2'b10, 8'd9, 8'd1, 0, "R2 count frozen");
        cyc(1, 1, 4'd1,  2'b10, 8'd9, 8'd1, 0, "R6 expire after freeze");
        // Random traffic
        for (int i = 0; i < 600; i++) begin
            logic md; logic [3:0] c; logic [1:0] v; logic [W-1:0] a, b; logic e;
            md = 1'($urandom);
            c  = 4'($urandom);
            v  = ($urandom % 6 == 0) ? 2'($urandom) : 2'b11;
            e  = ($urandom % 10 != 0);
            a  = 8'($urandom);
            b  = 8'($urandom);
            if (!md && c >= 12 && ($urandom % 2 == 0)) b = 8'($urandom % 16);
            cyc(e, md, c, v, a, b, 1'($urandom), md ? "R3 random" : "R4 random");
        end
        @(negedge clk);
        do_reset("R1 reset mid-run");
        summary();
        $finish;
    end
endmodule